// File: doc/BRIEF.md
# Bitwise Ternary Lookup Logic Unit

This unit evaluates an arbitrary three-input boolean function on 64-bit operands, bit by bit. The function is an 8-entry truth table. For every bit position the unit builds a 3-bit index from the old destination bit (most significant), the A bit and the B bit, and returns the table entry at that index. The destination word is therefore also the first source. The table comes either from a split immediate (a 5-bit low field and a 3-bit high field) or from the low byte of a fourth operand word, the table word C. A mode setting can collapse each operand to a single zero/nonzero flag, so that the whole result is the constant 1 or 0.

Two further forms work on narrower data. In the packed vec4 form, bytes 0, 1 and 2 of A are the x, y and z planes. One 8-bit result is computed from them and copied into each of the four low byte lanes of the destination whose mask bit is set. In the condition-field form, the lookup runs over the four low bits of D, A and B, and the result is written back into the low field of D only where the mask bit is set. In both forms all bits that are not written keep the old destination value.

Requests enter through a valid/ready handshake and leave through a one-entry valid/ready output register. The output is held stable while the consumer stalls. A new request is accepted only when the output register is empty or is being drained in the same cycle, so back-pressure reaches the producer in the same cycle.

Top module: `tlu_top`

## Requirements
- R1: With in_form=0 (immediate table) and in_mode other than 1, result bit i equals table bit {in_dst[i], in_a[i], in_b[i]}, where the table is {in_imm_hi, in_imm_lo} (in_imm_hi supplies table bits 7:5).
- R2: With in_form=1 (register table) the table is in_c[7:0], and the immediate fields have no effect on the result.
- R3: With in_mode=1 in forms 0 and 1, the result is 64'd1 when table bit {in_dst!=0, in_a!=0, in_b!=0} is set, and 64'd0 otherwise.
- R4: With in_form=2 (vec4), byte k of the lane value is, for each bit b, table bit {in_a[b], in_a[8+b], in_a[16+b]}. Byte lane j (bits 8j+7:8j, j=0..3) receives that value when in_mask[j] is 1 and keeps in_dst otherwise. Bits 63:32 equal in_dst.
- R5: With in_form=3 (condition field), result bit i (i=0..3) equals table bit {in_dst[i], in_a[i], in_b[i]} when in_mask[i] is 1 and equals in_dst[i] otherwise. Bits 63:4 equal in_dst. Forms 2 and 3 use the immediate table.
- R6: An accepted request (in_valid and in_ready both high at an edge) appears on out_result with out_valid high after that edge. While out_valid is high and out_ready is low, out_valid and out_result hold.
- R7: in_ready is high exactly when out_valid is low or out_ready is high.
- R8: After reset, out_valid is 0 and out_result is 0.
- R9: In forms 2 and 3 the value of in_mode has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request accepted at this edge if in_valid |
| in_form | input | 2 | 0 immediate table, 1 register table, 2 vec4, 3 condition field |
| in_mode | input | 2 | 1 selects whole-operand zero/nonzero mode (forms 0 and 1) |
| in_dst | input | 64 | Old destination, first lookup source |
| in_a | input | 64 | Second source (packed x/y/z source in vec4 form) |
| in_b | input | 64 | Third source |
| in_c | input | 64 | Table word, low byte used in form 1 |
| in_imm_lo | input | 5 | Table bits 4:0 |
| in_imm_hi | input | 3 | Table bits 7:5 |
| in_mask | input | 4 | Lane or field write mask |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result at this edge |
| out_result | output | 64 | Registered result |

## Verification
On every cycle the assertions check the handshake: an accepted request produces a valid result, a stalled result holds its value, and ready follows the output state. They also check the structural bounds of each form: the upper 63 bits are zero in whole-operand mode, and the destination passes through above the vec4 lanes and above the condition field. Only the bench scenarios can show that each truth-table entry is picked correctly. This includes majority, three-way XOR and bit-select tables, per-lane and per-bit masking, the choice of table source, and the mode being ignored in the narrow forms. The bench compares these against its behavioural model under random stalls.

// File: rtl/tlu_pkg.sv
package tlu_pkg;

  typedef enum logic [1:0] {
    FORM_IMM = 2'd0,
    FORM_REG = 2'd1,
    FORM_VEC = 2'd2,
    FORM_CRF = 2'd3
  } form_e;

  typedef enum logic [1:0] {
    MODE_BIT   = 2'd0,
    MODE_WHOLE = 2'd1,
    MODE_RSV2  = 2'd2,
    MODE_RSV3  = 2'd3
  } mode_e;

  localparam int TBL_W   = 8;
  localparam int TBL_IDX = 3;
  localparam int IMM_LO_W = 5;
  localparam int IMM_HI_W = TBL_W - IMM_LO_W;

endpackage

// File: rtl/tlu_lut_bank.sv
module tlu_lut_bank #(
  parameter int N = 64
) (
  input  logic [tlu_pkg::TBL_W-1:0] tbl,
  input  logic [N-1:0]              src_hi,
  input  logic [N-1:0]              src_mid,
  input  logic [N-1:0]              src_lo,
  output logic [N-1:0]              res
);
  for (genvar gi = 0; gi < N; gi++) begin : g_bit
    logic [tlu_pkg::TBL_IDX-1:0] idx;
    assign idx     = {src_hi[gi], src_mid[gi], src_lo[gi]};
    assign res[gi] = tbl[idx];
  end
endmodule

// File: rtl/tlu_lane_merge.sv
module tlu_lane_merge #(
  parameter int WIDTH  = 64,
  parameter int LANE_W = 8,
  parameter int LANES  = 4
) (
  input  logic [WIDTH-1:0]        old_word,
  input  logic [LANES*LANE_W-1:0] new_lanes,
  input  logic [LANES-1:0]        wr_mask,
  output logic [WIDTH-1:0]        merged
);
  localparam int COVER = LANES * LANE_W;

  for (genvar gj = 0; gj < LANES; gj++) begin : g_lane
    assign merged[gj*LANE_W +: LANE_W] =
      wr_mask[gj] ? new_lanes[gj*LANE_W +: LANE_W] : old_word[gj*LANE_W +: LANE_W];
  end

  if (WIDTH > COVER) begin : g_upper
    assign merged[WIDTH-1:COVER] = old_word[WIDTH-1:COVER];
  end
endmodule

// File: rtl/tlu_out_stage.sv
module tlu_out_stage #(
  parameter int WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_valid,
  output logic             load_ready,
  input  logic [WIDTH-1:0] load_data,
  output logic             q_valid,
  input  logic             q_ready,
  output logic [WIDTH-1:0] q_data
);
  assign load_ready = !q_valid || q_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_data  <= '0;
    end else if (load_ready) begin
      q_valid <= load_valid;
      if (load_valid) q_data <= load_data;
    end
  end

  // R6: an accepted request becomes visible after the edge
  p_load_shows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load_valid && load_ready |=> q_valid);

  // R6: a stalled result is held unchanged
  p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    q_valid && !q_ready |=> q_valid && $stable(q_data));

  // R6: a result only appears after an accept
  p_no_phantom_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q_valid) |-> $past(load_valid && load_ready));
endmodule

// File: rtl/tlu_top.sv
module tlu_top #(
  parameter int WIDTH  = 64,
  parameter int LANE_W = 8,
  parameter int MASK_W = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [1:0]                    in_form,
  input  logic [1:0]                    in_mode,
  input  logic [WIDTH-1:0]              in_dst,
  input  logic [WIDTH-1:0]              in_a,
  input  logic [WIDTH-1:0]              in_b,
  input  logic [WIDTH-1:0]              in_c,
  input  logic [tlu_pkg::IMM_LO_W-1:0]  in_imm_lo,
  input  logic [tlu_pkg::IMM_HI_W-1:0]  in_imm_hi,
  input  logic [MASK_W-1:0]             in_mask,
  output logic                          out_valid,
  input  logic                          out_ready,
  output logic [WIDTH-1:0]              out_result
);
  import tlu_pkg::*;

  localparam int LANES   = MASK_W;
  localparam int FIELD_W = MASK_W;
  localparam int VEC_W   = LANES * LANE_W;
  localparam int X_LSB   = 0;
  localparam int Y_LSB   = LANE_W;
  localparam int Z_LSB   = 2 * LANE_W;

  form_e form;
  mode_e mode;
  assign form = form_e'(in_form);
  assign mode = mode_e'(in_mode);

  // Table selection: split immediate or low byte of the table word
  logic [TBL_W-1:0] tbl_imm, tbl_sel;
  assign tbl_imm = {in_imm_hi, in_imm_lo};
  assign tbl_sel = (form == FORM_REG) ? in_c[TBL_W-1:0] : tbl_imm;

  logic unused_c_hi;
  assign unused_c_hi = ^in_c[WIDTH-1:TBL_W];

  // Full-width bitwise lookup
  logic [WIDTH-1:0] wide_res;
  tlu_lut_bank #(.N(WIDTH)) u_wide (
    .tbl(tbl_sel), .src_hi(in_dst), .src_mid(in_a), .src_lo(in_b), .res(wide_res)
  );

  // Whole-operand zero/nonzero lookup
  logic [2:0] nz_flags;
  logic       whole_bit;
  assign nz_flags  = {|in_dst, |in_a, |in_b};
  assign whole_bit = tbl_sel[nz_flags];

  // Packed vec4: x/y/z planes from the low three bytes of A
  logic [LANE_W-1:0] vec_byte;
  tlu_lut_bank #(.N(LANE_W)) u_vec (
    .tbl(tbl_imm),
    .src_hi(in_a[X_LSB +: LANE_W]),
    .src_mid(in_a[Y_LSB +: LANE_W]),
    .src_lo(in_a[Z_LSB +: LANE_W]),
    .res(vec_byte)
  );

  logic [WIDTH-1:0] vec_word;
  tlu_lane_merge #(.WIDTH(WIDTH), .LANE_W(LANE_W), .LANES(LANES)) u_vec_merge (
    .old_word(in_dst), .new_lanes({LANES{vec_byte}}), .wr_mask(in_mask), .merged(vec_word)
  );

  // Condition field: low FIELD_W bits, masked per bit
  logic [FIELD_W-1:0] crf_bits;
  tlu_lut_bank #(.N(FIELD_W)) u_crf (
    .tbl(tbl_imm),
    .src_hi(in_dst[FIELD_W-1:0]),
    .src_mid(in_a[FIELD_W-1:0]),
    .src_lo(in_b[FIELD_W-1:0]),
    .res(crf_bits)
  );

  logic [WIDTH-1:0] crf_word;
  tlu_lane_merge #(.WIDTH(WIDTH), .LANE_W(1), .LANES(FIELD_W)) u_crf_merge (
    .old_word(in_dst), .new_lanes(crf_bits), .wr_mask(in_mask), .merged(crf_word)
  );

  // Result select
  logic [WIDTH-1:0] next_res;
  always_comb begin
    case (form)
      FORM_VEC: next_res = vec_word;
      FORM_CRF: next_res = crf_word;
      default: begin
        if (mode == MODE_WHOLE) next_res = {{(WIDTH-1){1'b0}}, whole_bit};
        else                    next_res = wide_res;
      end
    endcase
  end

  tlu_out_stage #(.WIDTH(WIDTH)) u_out (
    .clk(clk), .rst_n(rst_n),
    .load_valid(in_valid), .load_ready(in_ready), .load_data(next_res),
    .q_valid(out_valid), .q_ready(out_ready), .q_data(out_result)
  );

  logic accept;
  assign accept = in_valid && in_ready;

  // R3: whole-operand mode leaves only bit 0 possibly set
  p_whole_narrow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (form == FORM_IMM || form == FORM_REG) && mode == MODE_WHOLE
    |=> out_result[WIDTH-1:1] == '0);

  // R4: destination passes through above the vec4 lanes
  p_vec_upper_r4: assert property (@(posedge clk) disable iff (!rst_n)
    accept && form == FORM_VEC
    |=> out_result[WIDTH-1:VEC_W] == $past(in_dst[WIDTH-1:VEC_W]));

  // R5: destination passes through above the condition field
  p_crf_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
    accept && form == FORM_CRF
    |=> out_result[WIDTH-1:FIELD_W] == $past(in_dst[WIDTH-1:FIELD_W]));

  // R5: a field bit with a clear mask keeps the old destination bit
  p_crf_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    accept && form == FORM_CRF && in_mask == '0
    |=> out_result == $past(in_dst));

  // R7: a stalled output blocks new requests
  p_backpressure_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
endmodule

// File: tb/tlu_top_tb_top.sv
`timescale 1ns/100ps
module tlu_top_tb_top;
  localparam real HALF = 2.5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_form = '0;
  logic [1:0]  in_mode = '0;
  logic [63:0] in_dst = '0, in_a = '0, in_b = '0, in_c = '0;
  logic [4:0]  in_imm_lo = '0;
  logic [2:0]  in_imm_hi = '0;
  logic [3:0]  in_mask = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_result;

  always #(HALF) clk = ~clk;

  tlu_top dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_form(in_form), .in_mode(in_mode), .in_dst(in_dst), .in_a(in_a),
    .in_b(in_b), .in_c(in_c), .in_imm_lo(in_imm_lo), .in_imm_hi(in_imm_hi),
    .in_mask(in_mask), .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result)
  );

  int    total = 0;
  int    bad = 0;
  bit    done = 1'b0;
  string cur_req = "R8";

  // Behavioural reference of the lookup
  function automatic logic [63:0] ref_calc(input logic [1:0] f, input logic [1:0] m,
      input logic [63:0] d, input logic [63:0] a, input logic [63:0] b,
      input logic [63:0] c, input logic [4:0] lo, input logic [2:0] hi,
      input logic [3:0] mk);
    logic [7:0]  t;
    logic [63:0] r;
    int          ix;
    t = (f == 2'd1) ? c[7:0] : {hi, lo};
    r = d;
    if (f == 2'd0 || f == 2'd1) begin
      if (m == 2'd1) begin
        ix = (d != 0 ? 4 : 0) + (a != 0 ? 2 : 0) + (b != 0 ? 1 : 0);
        r = {63'd0, t[ix]};
      end else begin
        for (int i = 0; i < 64; i++) begin
          ix = d[i] * 4 + a[i] * 2 + b[i];
          r[i] = t[ix];
        end
      end
    end else if (f == 2'd2) begin
      for (int j = 0; j < 4; j++)
        if (mk[j])
          for (int k = 0; k < 8; k++) begin
            ix = a[k] * 4 + a[8+k] * 2 + a[16+k];
            r[8*j+k] = t[ix];
          end
    end else begin
      for (int i = 0; i < 4; i++)
        if (mk[i]) begin
          ix = d[i] * 4 + a[i] * 2 + b[i];
          r[i] = t[ix];
        end
    end
    return r;
  endfunction

  // Cycle model of the output register
  logic        m_valid = 1'b0;
  logic [63:0] m_result = '0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_valid  <= 1'b0;
      m_result <= '0;
    end else if (!m_valid || out_ready) begin
      m_valid <= in_valid;
      if (in_valid)
        m_result <= ref_calc(in_form, in_mode, in_dst, in_a, in_b, in_c,
                             in_imm_lo, in_imm_hi, in_mask);
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (rst_n) begin
      chk(cur_req, "out_valid", 64'(out_valid), 64'(m_valid));
      chk("R7", "in_ready", 64'(in_ready), 64'(!m_valid || out_ready));
      if (m_valid) chk(cur_req, "out_result", out_result, m_result);
    end
  endtask

  task automatic drive(input logic [1:0] f, input logic [1:0] m, input logic [63:0] d,
      input logic [63:0] a, input logic [63:0] b, input logic [63:0] c,
      input logic [7:0] t, input logic [3:0] mk);
    in_form = f; in_mode = m; in_dst = d; in_a = a; in_b = b; in_c = c;
    in_imm_lo = t[4:0]; in_imm_hi = t[7:5]; in_mask = mk;
  endtask

  // One request with out_ready high; the directed expected value is checked
  task automatic one(input string req, input logic [1:0] f, input logic [1:0] m,
      input logic [63:0] d, input logic [63:0] a, input logic [63:0] b,
      input logic [63:0] c, input logic [7:0] t, input logic [3:0] mk,
      input logic [63:0] exp);
    cur_req = req;
    out_ready = 1'b1;
    drive(f, m, d, a, b, c, t, mk);
    in_valid = 1'b1;
    step();
    in_valid = 1'b0;
    chk(req, "directed", out_result, exp);
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  initial begin
    #(HALF * 2 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL R6 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] d, a, b, c, r0, r1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    chk("R8", "reset out_valid", 64'(out_valid), 64'd0);
    chk("R8", "reset out_result", out_result, 64'd0);

    // R1: majority, three-way XOR and bit select tables
    for (int n = 0; n < 6; n++) begin
      d = rnd64(); a = rnd64(); b = rnd64();
      one("R1", 2'd0, 2'd0, d, a, b, rnd64(), 8'hE8, 4'h0, (d & a) | (d & b) | (a & b));
      one("R1", 2'd0, 2'd2, d, a, b, rnd64(), 8'h96, 4'h0, d ^ a ^ b);
      one("R1", 2'd0, 2'd3, d, a, b, rnd64(), 8'hCA, 4'h0, (d & a) | (~d & b));
    end

    // R2: table from the word, immediate ignored
    for (int n = 0; n < 6; n++) begin
      d = rnd64(); a = rnd64(); b = rnd64();
      c = {rnd64() & 64'hFFFF_FFFF_FFFF_FF00} | 64'hE8;
      one("R2", 2'd1, 2'd0, d, a, b, c, 8'h00, 4'hF, (d & a) | (d & b) | (a & b));
      c = rnd64();
      one("R2", 2'd1, 2'd0, d, a, b, c, 8'(n * 37), 4'h0,
          ref_calc(2'd1, 2'd0, d, a, b, c, 5'd0, 3'd0, 4'h0));
    end

    // R3: whole-operand mode with zero operands
    one("R3", 2'd0, 2'd1, 64'd0, 64'd5, 64'd0, 64'd0, 8'h04, 4'h0, 64'd1);
    one("R3", 2'd0, 2'd1, 64'd0, 64'd5, 64'd0, 64'd0, 8'hFB, 4'h0, 64'd0);
    one("R3", 2'd0, 2'd1, 64'd0, 64'd0, 64'd0, 64'd0, 8'h01, 4'h0, 64'd1);
    one("R3", 2'd1, 2'd1, 64'h8000_0000_0000_0000, 64'd1, 64'd2, 64'h80, 8'h00, 4'h0, 64'd1);
    one("R3", 2'd1, 2'd1, 64'h8000_0000_0000_0000, 64'd1, 64'd2, 64'h7F, 8'hFF, 4'h0, 64'd0);

    // R4: vec4 lanes with masks
    d = 64'hDEAD_BEEF_0123_4567;
    a = 64'hFFFF_FFFF_FF33_0F55;
    // x=55 y=0F z=33; majority byte = 0x17
    one("R4", 2'd2, 2'd0, d, a, 64'd0, 64'd0, 8'hE8, 4'hF, 64'hDEAD_BEEF_1717_1717);
    one("R4", 2'd2, 2'd0, d, a, 64'd0, 64'd0, 8'hE8, 4'h0, d);
    one("R4", 2'd2, 2'd0, d, a, 64'd0, 64'd0, 8'hE8, 4'h5, 64'hDEAD_BEEF_0117_4517);
    // XOR byte = 55^0F^33 = 0x69
    one("R4", 2'd2, 2'd0, d, a, 64'd0, 64'd0, 8'h96, 4'hA, 64'hDEAD_BEEF_6923_6967);

    // R5: condition field, masked per bit
    d = 64'hAAAA_5555_0000_FFF5; a = 64'h3; b = 64'h9;
    // xor of d[3:0]=5,a=3,b=9 -> F
    one("R5", 2'd3, 2'd0, d, a, b, 64'd0, 8'h96, 4'hF, 64'hAAAA_5555_0000_FFFF);
    one("R5", 2'd3, 2'd0, d, a, b, 64'd0, 8'h96, 4'h0, d);
    one("R5", 2'd3, 2'd0, d, a, b, 64'd0, 8'h96, 4'h8, 64'hAAAA_5555_0000_FFFD);
    one("R5", 2'd3, 2'd0, d, a, b, 64'd0, 8'h00, 4'h3, 64'hAAAA_5555_0000_FFF4);

    // R9: mode has no effect in vec4 and condition forms
    for (int f = 2; f < 4; f++) begin
      d = rnd64(); a = rnd64(); b = rnd64();
      r0 = ref_calc(2'(f), 2'd0, d, a, b, 64'd0, 5'h1A, 3'h5, 4'h6);
      one("R9", 2'(f), 2'd1, d, a, b, 64'd0, 8'hBA, 4'h6, r0);
      r1 = out_result;
      one("R9", 2'(f), 2'd3, d, a, b, 64'd0, 8'hBA, 4'h6, r1);
    end

    // R6/R7: random traffic under random stalls, compared every cycle
    cur_req = "R6";
    for (int n = 0; n < 3000; n++) begin
      drive(2'($urandom), 2'($urandom), rnd64(), rnd64(), rnd64(), rnd64(),
            8'($urandom), 4'($urandom));
      in_valid  = ($urandom % 3) != 0;
      out_ready = ($urandom % 2) != 0;
      step();
    end
    in_valid = 1'b0; out_ready = 1'b1;
    step(); step();
    chk("R6", "drained", 64'(out_valid), 64'd0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule